// File: doc/BRIEF.md
# Split-Radix L-Shaped Butterfly Unit

This block computes one L-shaped butterfly of a split-radix FFT stage on complex signed integer samples. Each token carries four samples taken from a sub-sequence of length N at positions n, n+N/4, n+N/2 and n+3N/4 (called x0, x1, x2 and x3 here). The block returns two outputs for the half-length even sub-transform, the pointwise sums x0+x2 and x1+x3. It also returns two odd-quarter outputs. Each odd-quarter output is a ±j-combined difference term multiplied by its own quantized twiddle factor.

The twiddle factors are supplied with each token by an external lookup, because they depend only on n and the level length. They are signed fixed-point numbers with `FRAC_W` fractional bits, so that a value `t` stands for `t / 2^FRAC_W`. The first odd output uses the W^n kind and the second uses the W^3n kind. The level code and the index n travel as sideband fields alongside the data.

The datapath is a two-register pipeline with valid/ready handshakes on both sides. It stalls as a whole when the consumer is not ready.

Top module: `srb_lbfly`

## Requirements
- R1: In the cycle after reset is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The even outputs are exact sums, `out_e0 = x0 + x2` and `out_e1 = x1 + x3`, applied to the real and imaginary parts separately. They are `DATA_W+1` bits wide, so there is no overflow.
- R3: The first odd output is `o1 = floor(u1 * w1 / 2^FRAC_W)`, taken per component. Here `u1 = (x0 - x2) - j(x1 - x3)`, that is `u1.re = (x0-x2).re + (x1-x3).im` and `u1.im = (x0-x2).im - (x1-x3).re`. The product terms are `re = u.re*w.re - u.im*w.im` and `im = u.re*w.im + u.im*w.re`, and the floor is an arithmetic right shift.
- R4: The second odd output is `o3 = floor(u3 * w3 / 2^FRAC_W)`, computed in the same way with `u3 = (x0 - x2) + j(x1 - x3)`.
- R5: A twiddle equal to exactly one (real part `2^FRAC_W`, imaginary part 0), which is the case for n = 0, passes `u1` or `u3` through unchanged.
- R6: The level code and the index come out with the same token as the data they entered with.
- R7: A token accepted at a clock edge is presented on the outputs after the next edge. While `out_ready` stays high, one token is accepted every cycle and tokens leave in the order they arrived.
- R8: While `out_valid` is 1 and `out_ready` is 0, all outputs hold their values. With both pipeline registers full, `in_ready` is 0, and no token is lost or duplicated.
- R9: Full-scale inputs, including the most negative sample values and twiddle components of ±2^FRAC_W, produce exact results without wraparound. The odd outputs are `DATA_W+3` bits wide.
- R10: Whenever `out_ready` is 1, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input token present |
| in_ready | output | 1 | Block can take a token this cycle |
| in_x0_re | input | DATA_W | Sample at n, real |
| in_x0_im | input | DATA_W | Sample at n, imaginary |
| in_x1_re | input | DATA_W | Sample at n+N/4, real |
| in_x1_im | input | DATA_W | Sample at n+N/4, imaginary |
| in_x2_re | input | DATA_W | Sample at n+N/2, real |
| in_x2_im | input | DATA_W | Sample at n+N/2, imaginary |
| in_x3_re | input | DATA_W | Sample at n+3N/4, real |
| in_x3_im | input | DATA_W | Sample at n+3N/4, imaginary |
| in_w1_re | input | FRAC_W+2 | W^n twiddle, real, fixed point |
| in_w1_im | input | FRAC_W+2 | W^n twiddle, imaginary |
| in_w3_re | input | FRAC_W+2 | W^3n twiddle, real |
| in_w3_im | input | FRAC_W+2 | W^3n twiddle, imaginary |
| in_lvl | input | LVL_W | Level length code (sideband) |
| in_idx | input | IDX_W | Index n (sideband) |
| out_valid | output | 1 | Output token present |
| out_ready | input | 1 | Consumer takes the token |
| out_e0_re | output | DATA_W+1 | x0+x2, real |
| out_e0_im | output | DATA_W+1 | x0+x2, imaginary |
| out_e1_re | output | DATA_W+1 | x1+x3, real |
| out_e1_im | output | DATA_W+1 | x1+x3, imaginary |
| out_o1_re | output | DATA_W+3 | First odd output, real |
| out_o1_im | output | DATA_W+3 | First odd output, imaginary |
| out_o3_re | output | DATA_W+3 | Second odd output, real |
| out_o3_im | output | DATA_W+3 | Second odd output, imaginary |
| out_lvl | output | LVL_W | Level code of this token |
| out_idx | output | IDX_W | Index of this token |

## Verification
Mixed-sign samples with general quantized twiddles exercise the full arithmetic. Distinct real and imaginary values in all four inputs reveal any swap of a ±j direction, of an operand pair, or of the two twiddle kinds. Unity twiddles and pure ±j twiddles isolate the rotation, so an error there cannot be masked by the difference network. Full-scale negative and positive samples show whether any width is short. Back-to-back streams and consumer stalls tell a correct hand-off apart from a lost, duplicated or reordered token.

// File: rtl/srb_pkg.sv
package srb_pkg;

    // Default sizes used by the top module and the bench.
    localparam int DEF_DATA_W = 12;
    localparam int DEF_FRAC_W = 2;
    localparam int DEF_LVL_W  = 4;
    localparam int DEF_IDX_W  = 8;

    // Direction of the quarter-turn applied to the (x1 - x3) difference.
    typedef enum logic {
        ROT_NEG_J = 1'b0,   // u = d02 - j*d13  (W^n branch)
        ROT_POS_J = 1'b1    // u = d02 + j*d13  (W^3n branch)
    } rot_dir_e;

    // Width of an odd-quarter output: one bit per adder level (two levels),
    // plus one for the sum of two twiddle products.
    function automatic int odd_width(input int data_w);
        return data_w + 3;
    endfunction

    // Width of a twiddle component: sign, integer one, fraction bits.
    function automatic int tw_width(input int frac_w);
        return frac_w + 2;
    endfunction

endpackage

// File: rtl/srb_presum.sv
// First adder level: pairwise sums and differences of the four inputs.
module srb_presum #(
    parameter int DATA_W = srb_pkg::DEF_DATA_W,
    localparam int SW = DATA_W + 1
) (
    input  logic signed [DATA_W-1:0] x0_re,
    input  logic signed [DATA_W-1:0] x0_im,
    input  logic signed [DATA_W-1:0] x1_re,
    input  logic signed [DATA_W-1:0] x1_im,
    input  logic signed [DATA_W-1:0] x2_re,
    input  logic signed [DATA_W-1:0] x2_im,
    input  logic signed [DATA_W-1:0] x3_re,
    input  logic signed [DATA_W-1:0] x3_im,
    output logic signed [SW-1:0]     s02_re,
    output logic signed [SW-1:0]     s02_im,
    output logic signed [SW-1:0]     s13_re,
    output logic signed [SW-1:0]     s13_im,
    output logic signed [SW-1:0]     d02_re,
    output logic signed [SW-1:0]     d02_im,
    output logic signed [SW-1:0]     d13_re,
    output logic signed [SW-1:0]     d13_im
);

    always_comb begin
        s02_re = SW'(x0_re) + SW'(x2_re);
        s02_im = SW'(x0_im) + SW'(x2_im);
        s13_re = SW'(x1_re) + SW'(x3_re);
        s13_im = SW'(x1_im) + SW'(x3_im);
        d02_re = SW'(x0_re) - SW'(x2_re);
        d02_im = SW'(x0_im) - SW'(x2_im);
        d13_re = SW'(x1_re) - SW'(x3_re);
        d13_im = SW'(x1_im) - SW'(x3_im);
    end

endmodule

// File: rtl/srb_rotor.sv
// Second adder level (quarter-turn by swap and negate) followed by the
// quantized twiddle product and the fixed-point rescale.
module srb_rotor #(
    parameter int               IN_W   = srb_pkg::DEF_DATA_W + 1,
    parameter int               FRAC_W = srb_pkg::DEF_FRAC_W,
    parameter int               OUT_W  = srb_pkg::DEF_DATA_W + 3,
    parameter srb_pkg::rot_dir_e DIR   = srb_pkg::ROT_NEG_J,
    localparam int TW_W = srb_pkg::tw_width(FRAC_W),
    localparam int UW   = IN_W + 1,
    localparam int PW   = UW + TW_W + 1
) (
    input  logic signed [IN_W-1:0]  d02_re,
    input  logic signed [IN_W-1:0]  d02_im,
    input  logic signed [IN_W-1:0]  d13_re,
    input  logic signed [IN_W-1:0]  d13_im,
    input  logic signed [TW_W-1:0]  w_re,
    input  logic signed [TW_W-1:0]  w_im,
    output logic signed [OUT_W-1:0] o_re,
    output logic signed [OUT_W-1:0] o_im
);

    logic signed [UW-1:0] u_re, u_im;
    logic signed [PW-1:0] p_re, p_im;

    // j*(a + ib) = -b + ia : no multiplier, only a swap and a negation.
    generate
        if (DIR == srb_pkg::ROT_NEG_J) begin : g_neg
            always_comb begin
                u_re = UW'(d02_re) + UW'(d13_im);
                u_im = UW'(d02_im) - UW'(d13_re);
            end
        end else begin : g_pos
            always_comb begin
                u_re = UW'(d02_re) - UW'(d13_im);
                u_im = UW'(d02_im) + UW'(d13_re);
            end
        end
    endgenerate

    always_comb begin
        p_re = PW'(u_re) * PW'(w_re) - PW'(u_im) * PW'(w_im);
        p_im = PW'(u_re) * PW'(w_im) + PW'(u_im) * PW'(w_re);
        o_re = OUT_W'(p_re >>> FRAC_W);
        o_im = OUT_W'(p_im >>> FRAC_W);
    end

endmodule

// File: rtl/srb_lbfly.sv
module srb_lbfly #(
    parameter int DATA_W = srb_pkg::DEF_DATA_W,
    parameter int FRAC_W = srb_pkg::DEF_FRAC_W,
    parameter int LVL_W  = srb_pkg::DEF_LVL_W,
    parameter int IDX_W  = srb_pkg::DEF_IDX_W,
    localparam int SW   = DATA_W + 1,
    localparam int OW   = srb_pkg::odd_width(DATA_W),
    localparam int TW_W = srb_pkg::tw_width(FRAC_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [DATA_W-1:0] in_x0_re,
    input  logic signed [DATA_W-1:0] in_x0_im,
    input  logic signed [DATA_W-1:0] in_x1_re,
    input  logic signed [DATA_W-1:0] in_x1_im,
    input  logic signed [DATA_W-1:0] in_x2_re,
    input  logic signed [DATA_W-1:0] in_x2_im,
    input  logic signed [DATA_W-1:0] in_x3_re,
    input  logic signed [DATA_W-1:0] in_x3_im,
    input  logic signed [TW_W-1:0]  in_w1_re,
    input  logic signed [TW_W-1:0]  in_w1_im,
    input  logic signed [TW_W-1:0]  in_w3_re,
    input  logic signed [TW_W-1:0]  in_w3_im,
    input  logic [LVL_W-1:0]        in_lvl,
    input  logic [IDX_W-1:0]        in_idx,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [SW-1:0]    out_e0_re,
    output logic signed [SW-1:0]    out_e0_im,
    output logic signed [SW-1:0]    out_e1_re,
    output logic signed [SW-1:0]    out_e1_im,
    output logic signed [OW-1:0]    out_o1_re,
    output logic signed [OW-1:0]    out_o1_im,
    output logic signed [OW-1:0]    out_o3_re,
    output logic signed [OW-1:0]    out_o3_im,
    output logic [LVL_W-1:0]        out_lvl,
    output logic [IDX_W-1:0]        out_idx
);

    typedef logic signed [SW-1:0]   sum_t;
    typedef logic signed [TW_W-1:0] tw_t;
    typedef logic signed [OW-1:0]   odd_t;

    typedef struct packed {
        sum_t s02_re, s02_im, s13_re, s13_im;
        sum_t d02_re, d02_im, d13_re, d13_im;
        tw_t  w1_re, w1_im, w3_re, w3_im;
        logic [LVL_W-1:0] lvl;
        logic [IDX_W-1:0] idx;
    } mid_t;

    typedef struct packed {
        sum_t e0_re, e0_im, e1_re, e1_im;
        odd_t o1_re, o1_im, o3_re, o3_im;
        logic [LVL_W-1:0] lvl;
        logic [IDX_W-1:0] idx;
    } fin_t;

    // ---------------- handshake: whole-pipe stall ----------------
    logic v_mid, v_fin;
    logic adv_mid, adv_fin;

    assign adv_fin  = !v_fin || out_ready;
    assign adv_mid  = !v_mid || adv_fin;
    assign in_ready = adv_mid;

    // ---------------- stage 1: sums and differences ----------------
    mid_t mid_d, mid_q;

    srb_presum #(.DATA_W(DATA_W)) presum_i (
        .x0_re(in_x0_re), .x0_im(in_x0_im),
        .x1_re(in_x1_re), .x1_im(in_x1_im),
        .x2_re(in_x2_re), .x2_im(in_x2_im),
        .x3_re(in_x3_re), .x3_im(in_x3_im),
        .s02_re(mid_d.s02_re), .s02_im(mid_d.s02_im),
        .s13_re(mid_d.s13_re), .s13_im(mid_d.s13_im),
        .d02_re(mid_d.d02_re), .d02_im(mid_d.d02_im),
        .d13_re(mid_d.d13_re), .d13_im(mid_d.d13_im)
    );

    always_comb begin
        mid_d.w1_re = in_w1_re;
        mid_d.w1_im = in_w1_im;
        mid_d.w3_re = in_w3_re;
        mid_d.w3_im = in_w3_im;
        mid_d.lvl   = in_lvl;
        mid_d.idx   = in_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_mid <= 1'b0;
            mid_q <= '0;
        end else if (adv_mid) begin
            v_mid <= in_valid;
            mid_q <= mid_d;
        end
    end

    // ---------------- stage 2: quarter turns and twiddles ----------------
    tw_t  tw_re  [2];
    tw_t  tw_im  [2];
    odd_t rot_re [2];
    odd_t rot_im [2];

    assign tw_re[0] = mid_q.w1_re;
    assign tw_im[0] = mid_q.w1_im;
    assign tw_re[1] = mid_q.w3_re;
    assign tw_im[1] = mid_q.w3_im;

    generate
        for (genvar k = 0; k < 2; k++) begin : g_rot
            localparam srb_pkg::rot_dir_e KDIR =
                (k == 0) ? srb_pkg::ROT_NEG_J : srb_pkg::ROT_POS_J;
            srb_rotor #(
                .IN_W(SW), .FRAC_W(FRAC_W), .OUT_W(OW), .DIR(KDIR)
            ) rotor_i (
                .d02_re(mid_q.d02_re), .d02_im(mid_q.d02_im),
                .d13_re(mid_q.d13_re), .d13_im(mid_q.d13_im),
                .w_re(tw_re[k]), .w_im(tw_im[k]),
                .o_re(rot_re[k]), .o_im(rot_im[k])
            );
        end
    endgenerate

    fin_t fin_d, fin_q;

    always_comb begin
        fin_d.e0_re = mid_q.s02_re;
        fin_d.e0_im = mid_q.s02_im;
        fin_d.e1_re = mid_q.s13_re;
        fin_d.e1_im = mid_q.s13_im;
        fin_d.o1_re = rot_re[0];
        fin_d.o1_im = rot_im[0];
        fin_d.o3_re = rot_re[1];
        fin_d.o3_im = rot_im[1];
        fin_d.lvl   = mid_q.lvl;
        fin_d.idx   = mid_q.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_fin <= 1'b0;
            fin_q <= '0;
        end else if (adv_fin) begin
            v_fin <= v_mid;
            fin_q <= fin_d;
        end
    end

    assign out_valid = v_fin;
    assign out_e0_re = fin_q.e0_re;
    assign out_e0_im = fin_q.e0_im;
    assign out_e1_re = fin_q.e1_re;
    assign out_e1_im = fin_q.e1_im;
    assign out_o1_re = fin_q.o1_re;
    assign out_o1_im = fin_q.o1_im;
    assign out_o3_re = fin_q.o3_re;
    assign out_o3_im = fin_q.o3_im;
    assign out_lvl   = fin_q.lvl;
    assign out_idx   = fin_q.idx;

endmodule

// File: rtl/srb_lbfly_chk.sv
module srb_lbfly_chk #(
    parameter int DATA_W = srb_pkg::DEF_DATA_W,
    parameter int IDX_W  = srb_pkg::DEF_IDX_W,
    localparam int SW = DATA_W + 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic signed [DATA_W-1:0] in_x0_re,
    input logic signed [DATA_W-1:0] in_x2_re,
    input logic signed [SW-1:0]     out_e0_re,
    input logic [IDX_W-1:0]         in_idx,
    input logic [IDX_W-1:0]         out_idx
);

    logic signed [SW-1:0] e0_ref;
    assign e0_ref = SW'(in_x0_re) + SW'(in_x2_re);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && in_ready));

    a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_e0_re) && $stable(out_idx)));

    a_r10_ready_pass: assert property (@(posedge clk) disable iff (rst)
        out_ready |-> in_ready);

    a_r2_even_sum: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) ##1 out_ready |=>
            (out_valid && out_e0_re == $past(e0_ref, 2)));

    a_r6_idx_follow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) ##1 out_ready |=>
            (out_idx == $past(in_idx, 2)));

endmodule

bind srb_lbfly srb_lbfly_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .in_x0_re(in_x0_re), .in_x2_re(in_x2_re),
    .out_e0_re(out_e0_re),
    .in_idx(in_idx), .out_idx(out_idx)
);

// File: tb/srb_lbfly_tb_top.sv
module srb_lbfly_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 12;
    localparam int FW   = 2;
    localparam int LW   = 4;
    localparam int IW   = 8;
    localparam int SW   = DW + 1;
    localparam int OW   = DW + 3;
    localparam int TWW  = FW + 2;
    localparam int ONE  = 1 << FW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [DW-1:0] x0r = '0, x0i = '0, x1r = '0, x1i = '0;
    logic signed [DW-1:0] x2r = '0, x2i = '0, x3r = '0, x3i = '0;
    logic signed [TWW-1:0] w1r = '0, w1i = '0, w3r = '0, w3i = '0;
    logic [LW-1:0] lvl = '0;
    logic [IW-1:0] idx = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic signed [SW-1:0] e0r, e0i, e1r, e1i;
    logic signed [OW-1:0] o1r, o1i, o3r, o3i;
    logic [LW-1:0] olvl;
    logic [IW-1:0] oidx;

    always #(CLK_PERIOD/2) clk = ~clk;

    srb_lbfly #(.DATA_W(DW), .FRAC_W(FW), .LVL_W(LW), .IDX_W(IW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_x0_re(x0r), .in_x0_im(x0i), .in_x1_re(x1r), .in_x1_im(x1i),
        .in_x2_re(x2r), .in_x2_im(x2i), .in_x3_re(x3r), .in_x3_im(x3i),
        .in_w1_re(w1r), .in_w1_im(w1i), .in_w3_re(w3r), .in_w3_im(w3i),
        .in_lvl(lvl), .in_idx(idx),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_e0_re(e0r), .out_e0_im(e0i), .out_e1_re(e1r), .out_e1_im(e1i),
        .out_o1_re(o1r), .out_o1_im(o1i), .out_o3_re(o3r), .out_o3_im(o3i),
        .out_lvl(olvl), .out_idx(oidx)
    );

    typedef struct {
        int e0r, e0i, e1r, e1i, o1r, o1i, o3r, o3i, lv, ix;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_acc = 0;
    int got_o1r, got_o1i, got_o3r, got_o3i;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Output monitor: compares every transfer against the expected queue.
    always begin
        @(negedge clk);
        #2;
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected token", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R2 e0.re", int'(e0r), e.e0r);
                check("R2 e0.im", int'(e0i), e.e0i);
                check("R2 e1.re", int'(e1r), e.e1r);
                check("R2 e1.im", int'(e1i), e.e1i);
                check("R3 o1.re", int'(o1r), e.o1r);
                check("R3 o1.im", int'(o1i), e.o1i);
                check("R4 o3.re", int'(o3r), e.o3r);
                check("R4 o3.im", int'(o3i), e.o3i);
                check("R6 lvl",   int'(olvl), e.lv);
                check("R6 idx",   int'(oidx), e.ix);
                got_o1r = int'(o1r); got_o1i = int'(o1i);
                got_o3r = int'(o3r); got_o3i = int'(o3i);
            end
        end
    end

    function automatic exp_t model(input int xr[4], input int xi[4],
                                   input int a1r, input int a1i,
                                   input int a3r, input int a3i,
                                   input int lv, input int ix);
        exp_t e;
        int ar, ai, br, bi, u1r, u1i, u3r, u3i;
        ar = xr[0] - xr[2]; ai = xi[0] - xi[2];
        br = xr[1] - xr[3]; bi = xi[1] - xi[3];
        u1r = ar + bi; u1i = ai - br;
        u3r = ar - bi; u3i = ai + br;
        e.e0r = xr[0] + xr[2]; e.e0i = xi[0] + xi[2];
        e.e1r = xr[1] + xr[3]; e.e1i = xi[1] + xi[3];
        e.o1r = (u1r * a1r - u1i * a1i) >>> FW;
        e.o1i = (u1r * a1i + u1i * a1r) >>> FW;
        e.o3r = (u3r * a3r - u3i * a3i) >>> FW;
        e.o3i = (u3r * a3i + u3i * a3r) >>> FW;
        e.lv = lv; e.ix = ix;
        return e;
    endfunction

    // Presents one token, waits for acceptance, queues its expected result.
    task automatic send_tok(input int xr[4], input int xi[4],
                            input int a1r, input int a1i,
                            input int a3r, input int a3i,
                            input int lv, input int ix);
        @(negedge clk);
        x0r = DW'(xr[0]); x0i = DW'(xi[0]); x1r = DW'(xr[1]); x1i = DW'(xi[1]);
        x2r = DW'(xr[2]); x2i = DW'(xi[2]); x3r = DW'(xr[3]); x3i = DW'(xi[3]);
        w1r = TWW'(a1r); w1i = TWW'(a1i); w3r = TWW'(a3r); w3i = TWW'(a3i);
        lvl = LW'(lv); idx = IW'(ix);
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(xr, xi, a1r, a1i, a3r, a3i, lv, ix));
        @(posedge clk);
        last_acc = cyc;
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while (exp_q.size() != 0 && n < 60) begin
            @(negedge clk);
            n++;
        end
        check({req, " drained"}, exp_q.size(), 0);
        @(negedge clk);
        #3;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic t_basic();
        out_ready = 1'b1;
        send_tok('{100, -37, 250, 3}, '{-5, 44, -120, 17}, 3, -3, -3, -3, 5, 1);
        send_tok('{-800, 1200, 33, -1999}, '{700, -650, 1, 900}, 2, 3, -4, 1, 5, 6);
        send_tok('{1, 2, 3, 4}, '{-4, -3, -2, -1}, 4, -1, 0, 4, 3, 2);
        drain("R3 R4 basic");
    endtask

    task automatic t_unity();
        int ar, ai, br, bi;
        out_ready = 1'b1;
        send_tok('{321, -77, -140, 555}, '{-9, 413, 260, -31}, ONE, 0, ONE, 0, 6, 0);
        drain("R5 unity");
        ar = 321 - (-140); ai = -9 - 260; br = -77 - 555; bi = 413 - (-31);
        check("R5 o1.re passthrough", got_o1r, ar + bi);
        check("R5 o1.im passthrough", got_o1i, ai - br);
        check("R5 o3.re passthrough", got_o3r, ar - bi);
        check("R5 o3.im passthrough", got_o3i, ai + br);
    endtask

    task automatic t_quarter();
        out_ready = 1'b1;
        send_tok('{10, 20, 30, 40}, '{-50, 60, -70, 80}, 0, -ONE, 0, ONE, 2, 3);
        send_tok('{-1, 7, 5, -2}, '{9, -6, 3, 11}, -ONE, 0, 0, -ONE, 2, 1);
        drain("R3 R4 quarter");
    endtask

    task automatic t_extreme();
        out_ready = 1'b1;
        send_tok('{2047, -2048, -2048, 2047}, '{2047, 2047, -2048, -2048},
                 ONE, ONE, -ONE, -ONE, 15, 255);
        send_tok('{-2048, -2048, -2048, -2048}, '{-2048, -2048, -2048, -2048},
                 -ONE, 0, -ONE, 0, 0, 0);
        send_tok('{-2048, 2047, 2047, -2048}, '{-2048, -2048, 2047, 2047},
                 ONE, -ONE, -ONE, ONE, 9, 128);
        drain("R9 extreme");
    endtask

    task automatic t_latency();
        out_ready = 1'b1;
        send_tok('{5, 6, 7, 8}, '{1, 1, 1, 1}, ONE, 0, ONE, 0, 1, 0);
        check("R7 not valid at accept edge", int'(out_valid), 0);
        @(posedge clk);
        #1;
        check("R7 valid one edge later", int'(out_valid), 1);
        drain("R7 latency");
    endtask

    task automatic t_stream();
        int prev;
        out_ready = 1'b1;
        send_tok('{0, 1, 2, 3}, '{3, 2, 1, 0}, 3, 1, -1, 2, 4, 0);
        prev = last_acc;
        for (int k = 1; k < 8; k++) begin
            send_tok('{k * 11, -k, k * 3, 9 - k}, '{-k * 7, k, 2 * k, -3},
                     3, -k % 4, k % 4, -2, 4, k);
            check("R7 back-to-back accept", last_acc - prev, 1);
            prev = last_acc;
        end
        drain("R7 stream");
    endtask

    task automatic t_stall();
        int held;
        @(negedge clk);
        out_ready = 1'b0;
        send_tok('{100, 200, 300, 400}, '{1, 2, 3, 4}, ONE, 0, ONE, 0, 7, 10);
        held = exp_q[0].e0r;
        send_tok('{-9, 8, -7, 6}, '{5, -4, 3, -2}, 2, 2, -2, 2, 7, 11);
        @(negedge clk);
        #1;
        check("R8 in_ready low when full", int'(in_ready), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            check("R8 out_valid held", int'(out_valid), 1);
            check("R8 e0 held", int'(e0r), held);
            check("R8 idx held", int'(oidx), 10);
        end
        out_ready = 1'b1;
        #1;
        check("R10 in_ready with out_ready", int'(in_ready), 1);
        send_tok('{44, 33, 22, 11}, '{-1, -2, -3, -4}, 1, 1, 1, -1, 7, 12);
        drain("R8 stall order");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_basic();
        t_unity();
        t_quarter();
        t_extreme();
        t_latency();
        t_stream();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule